// File: doc/BRIEF.md
# Rotation Index Splitter for a Three-Stage Rotator

This block turns a 20-bit rotation index `phi`, which stands for the angle `phi * 2*pi / 2^20`, into three control words for a rotator built as three stages in series. The first stage is a quadrant stage that rotates by multiples of 90 degrees. The second is a coarse stage with 512 steps per turn. The third is a small-angle stage whose step is one part in 2^20 of a turn. Added together, the three stage angles give back the requested angle exactly.

The coarse index is rounded to the nearest step, not truncated. The fine residue is therefore signed and centred on zero, which halves the largest angle the small-angle stage has to cover. Each index comes with a valid strobe. The three control words appear on registered outputs one clock later, together with their own valid.

Top module: `angle_split`

## Requirements
- R1: While `rst_ni` is low, and after its release until the first accepted index, `valid_o` is 0 and `quad_o`, `coarse_o` and `fine_o` are all 0.
- R2: `valid_o` equals `valid_i` from the previous clock edge, so the latency is exactly one cycle.
- R3: `quad_o` equals bits [19:18] of the accepted index, which selects a quadrant of 0, 90, 180 or 270 degrees.
- R4: With `r` the low 18 bits of the index, `coarse_o` (unsigned, 8 bits) is `r/2048` rounded to the nearest integer, and it always lies in 0..128.
- R5: `fine_o` (two's complement, 12 bits) equals `r - 2048*coarse_o` and always lies in -1023..+1024.
- R6: `2^18*quad_o + 2048*coarse_o + fine_o` equals the accepted index exactly.
- R7: On a tie, where `r mod 2048` is 1024, the coarse index rounds down and `fine_o` is +1024.
- R8: When `r >= 2^18 - 1023`, `coarse_o` is 128 and `quad_o` still holds the quadrant of the index; the split never carries into the next quadrant.
- R9: A clock edge with `valid_i` low leaves `quad_o`, `coarse_o` and `fine_o` at their previous values and drives `valid_o` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Index strobe |
| idx_i | input | 20 | Rotation index, one turn = 2^20 |
| valid_o | output | 1 | Control triple valid, one cycle after `valid_i` |
| quad_o | output | 2 | Quadrant select for the trivial stage |
| coarse_o | output | 8 | Coarse step index, 0..128 |
| fine_o | output | 12 | Signed fine residue, -1023..+1024 |

## Verification
The outputs are a single register stage over combinational arithmetic. Any fault in the rounding compare, the residue subtraction or the capture enable therefore shows up on the cycle right after the index that triggers it. The fault appears as a residue outside -1023..+1024, a coarse index of 129, or a triple whose weighted sum differs from the index. A strided sweep across all four quadrants, plus directed ties and quadrant-edge indices, exposes faults that only show at one rounding boundary. A faulty hold path shows up as outputs that change on a cycle with no strobe.

// File: rtl/angle_split_pkg.sv
package angle_split_pkg;
  localparam int IDX_W      = 20;
  localparam int QUAD_W     = 2;
  localparam int COARSE_LOG = 9;

  localparam int REM_W   = IDX_W - QUAD_W;
  localparam int STEP_SH = IDX_W - COARSE_LOG;
  localparam int J_W     = COARSE_LOG - QUAD_W + 1;
  localparam int K_W     = STEP_SH + 1;
endpackage

// File: rtl/angle_coarse_round.sv
module angle_coarse_round #(
  parameter int REM_W   = 18,
  parameter int STEP_SH = 11,
  parameter int J_W     = 8
) (
  input  logic [REM_W-1:0]   rem_i,
  output logic [J_W-1:0]     coarse_o,
  output logic               up_o
);
  localparam int HI_W = REM_W - STEP_SH;
  localparam logic [STEP_SH-1:0] HALF = STEP_SH'(1) << (STEP_SH - 1);

  logic [STEP_SH-1:0] low;
  logic [HI_W-1:0]    hi;

  assign low = rem_i[STEP_SH-1:0];
  assign hi  = rem_i[REM_W-1:STEP_SH];

  // strict compare: a tie rounds down
  assign up_o     = low > HALF;
  assign coarse_o = J_W'({1'b0, hi}) + J_W'(up_o);
endmodule

// File: rtl/angle_fine_residue.sv
module angle_fine_residue #(
  parameter int STEP_SH = 11,
  parameter int K_W     = 12
) (
  input  logic [STEP_SH-1:0] low_i,
  input  logic               up_i,
  output logic [K_W-1:0]     fine_o
);
  localparam logic [K_W-1:0] STEP = K_W'(1) << STEP_SH;

  logic [K_W-1:0] low_ext;
  assign low_ext = {1'b0, low_i};

  always_comb begin
    if (up_i) fine_o = low_ext - STEP;
    else      fine_o = low_ext;
  end
endmodule

// File: rtl/angle_split.sv
module angle_split
  import angle_split_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  valid_i,
  input  logic [IDX_W-1:0]      idx_i,
  output logic                  valid_o,
  output logic [QUAD_W-1:0]     quad_o,
  output logic [J_W-1:0]        coarse_o,
  output logic signed [K_W-1:0] fine_o
);
  logic [REM_W-1:0] rem;
  logic [J_W-1:0]   coarse_d;
  logic             up;
  logic [K_W-1:0]   fine_d;

  assign rem = idx_i[REM_W-1:0];

  angle_coarse_round #(.REM_W(REM_W), .STEP_SH(STEP_SH), .J_W(J_W)) u_round (
    .rem_i    (rem),
    .coarse_o (coarse_d),
    .up_o     (up)
  );

  angle_fine_residue #(.STEP_SH(STEP_SH), .K_W(K_W)) u_fine (
    .low_i  (rem[STEP_SH-1:0]),
    .up_i   (up),
    .fine_o (fine_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      quad_o   <= '0;
      coarse_o <= '0;
      fine_o   <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        quad_o   <= idx_i[IDX_W-1:REM_W];
        coarse_o <= coarse_d;
        fine_o   <= signed'(fine_d);
      end
    end
  end
endmodule

// File: rtl/angle_split_chk.sv
module angle_split_chk
  import angle_split_pkg::*;
(
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  valid_i,
  input logic [IDX_W-1:0]      idx_i,
  input logic                  valid_o,
  input logic [QUAD_W-1:0]     quad_o,
  input logic [J_W-1:0]        coarse_o,
  input logic signed [K_W-1:0] fine_o
);
  localparam int MAX_J = 1 << (COARSE_LOG - QUAD_W);
  localparam int HALF  = 1 << (STEP_SH - 1);

  assert_latency_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == $past(valid_i));

  assert_quadrant_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> quad_o == $past(idx_i[IDX_W-1:REM_W]));

  assert_coarse_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> int'(coarse_o) <= MAX_J);

  assert_fine_range_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (int'(fine_o) >= 1 - HALF) && (int'(fine_o) <= HALF));

  assert_exact_sum_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ((int'(quad_o) <<< REM_W) + (int'(coarse_o) <<< STEP_SH) + int'(fine_o))
                == int'($past(idx_i)));

  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(quad_o) && $stable(coarse_o) && $stable(fine_o));
endmodule

bind angle_split angle_split_chk u_chk (
  .clk_i, .rst_ni, .valid_i, .idx_i, .valid_o, .quad_o, .coarse_o, .fine_o
);

// File: tb/sim_angle_split.sv
module sim_angle_split;
  typedef struct packed {
    logic [19:0]        idx;
    logic [1:0]         q;
    logic [7:0]         j;
    logic signed [11:0] k;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{20'h00000, 2'd0, 8'd0,   12'sd0},
    '{20'h00400, 2'd0, 8'd0,   12'sd1024},   // R7 tie
    '{20'h00401, 2'd0, 8'd1,  -12'sd1023},
    '{20'h00800, 2'd0, 8'd1,   12'sd0},
    '{20'h3FFFF, 2'd0, 8'd128, -12'sd1},     // R8
    '{20'h3FC01, 2'd0, 8'd128, -12'sd1023},  // R8 threshold
    '{20'h3FC00, 2'd0, 8'd127, 12'sd1024},
    '{20'h40000, 2'd1, 8'd0,   12'sd0},
    '{20'hFFFFF, 2'd3, 8'd128, -12'sd1},
    '{20'h80400, 2'd2, 8'd0,   12'sd1024},
    '{20'hC0C00, 2'd3, 8'd1,   12'sd1024},
    '{20'h12345, 2'd0, 8'd36,  12'sd837},
    '{20'hABCDE, 2'd2, 8'd88, -12'sd802}
  };

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               valid_i = 1'b0;
  logic [19:0]        idx_i = '0;
  logic               valid_o;
  logic [1:0]         quad_o;
  logic [7:0]         coarse_o;
  logic signed [11:0] fine_o;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  angle_split u0 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .idx_i(idx_i),
    .valid_o(valid_o), .quad_o(quad_o), .coarse_o(coarse_o), .fine_o(fine_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_triple(input string req, input int q, input int j, input int k);
    chk({req, " quad"}, int'(quad_o), q);
    chk({req, " coarse"}, int'(coarse_o), j);
    chk({req, " fine"}, int'(fine_o), k);
  endtask

  // independent model: nearest step with ties down
  function automatic int mdl_j(input int r);
    return (r + 1023) / 2048;
  endfunction

  task automatic sweep(input int stride);
    int prev = -1;
    for (int p = 0; p < (1 << 20); p += stride) begin
      @(posedge clk); #1;
      if (prev >= 0) begin
        int r = prev % (1 << 18);
        int j = mdl_j(r);
        int k = r - 2048 * j;
        chk("R2 sweep valid", int'(valid_o), 1);
        chk_triple("R3/R4/R5 sweep", prev >> 18, j, k);
        total++;
        if (int'(coarse_o) > 128 || int'(fine_o) < -1023 || int'(fine_o) > 1024 ||
            (int'(quad_o) * 262144 + int'(coarse_o) * 2048 + int'(fine_o)) != prev) begin
          bad++;
          $display("FAIL R6 sum idx=%0d actual q=%0d j=%0d k=%0d", prev,
                   quad_o, coarse_o, fine_o);
        end
      end
      valid_i = 1'b1;
      idx_i   = 20'(p);
      prev    = p;
    end
    @(posedge clk); #1;
    valid_i = 1'b0;
  endtask

  initial begin
    #1;
    chk("R1 reset valid", int'(valid_o), 0);
    chk_triple("R1 reset", 0, 0, 0);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1 idle valid", int'(valid_o), 0);
    chk_triple("R1 idle", 0, 0, 0);

    foreach (VECS[n]) begin
      valid_i = 1'b1;
      idx_i   = VECS[n].idx;
      @(posedge clk); #1;
      valid_i = 1'b0;
      chk("R2 table valid", int'(valid_o), 1);
      chk_triple("R4/R5/R7/R8 table", int'(VECS[n].q), int'(VECS[n].j), int'(VECS[n].k));
    end

    // R9: no strobe, new index must not be taken
    valid_i = 1'b1; idx_i = 20'h12345;
    @(posedge clk); #1;
    valid_i = 1'b0; idx_i = 20'hFFFFF;
    @(posedge clk); #1;
    chk("R9 valid low", int'(valid_o), 0);
    chk_triple("R9 hold", 0, 36, 837);
    @(posedge clk); #1;
    chk_triple("R9 hold2", 0, 36, 837);

    sweep(7);

    // R1: reset mid-run clears outputs
    valid_i = 1'b1; idx_i = 20'hABCDE;
    @(posedge clk); #1;
    valid_i = 1'b0;
    rst_n = 1'b0;
    #1;
    chk("R1 mid reset valid", int'(valid_o), 0);
    chk_triple("R1 mid reset", 0, 0, 0);
    rst_n = 1'b1;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule